// File: doc/BRIEF.md
# Stage-Based Die Temperature Estimator

This block produces a die temperature estimate, in millidegrees Celsius, from a coarse over-temperature alarm. No converter reading is involved. Three inputs feed it: the alarm's stage (or its wider state code), a 2-bit threshold code that places the alarm bands, and a select that says which alarm generation is attached. Only the stage code moves the estimate; the threshold code and the select are read when a strobe arrives. The block keeps the last stage code it was given. On each update strobe it compares the new stage with the stored one. If the stage went up, the estimate moves to just above the lower edge of the new band. If it went down, the estimate moves to just below the upper edge of the new band. If the stage is the same, the estimate stays where it was.

Until an init strobe arrives, the output holds a fixed body-temperature default and the valid flag is low. Update strobes in that period have no effect. The init strobe seeds the stored stage and sets the estimate to the band's lower edge with no hysteresis. One cycle later the valid flag rises, and it stays high until reset.

Top module: `thermstage_est`

## Requirements
- R1: After reset, `est_o` is 37000 and `valid_o` is 0. Both hold these values until the first init strobe.
- R2: An `upd_i` pulse that arrives while `valid_o` is 0 has no effect: `est_o` stays 37000 and `valid_o` stays 0.
- R3: An `init_i` pulse stores `state_i`. It sets `est_o` to 37000 when the mapped stage s is 0, and otherwise to t*5000 + (s-1)*20000 + 105000, where t is `thr_i` taken as unsigned. `valid_o` reads 1 from the edge that takes the init, and stays 1 until reset.
- R4: An update whose mapped new stage n is above the mapped stored stage sets `est_o` to (n-1)*20000 + t*5000 + 2000 + 105000.
- R5: An update whose mapped new stage n is below the mapped stored stage sets `est_o` to n*20000 + t*5000 - 2000 + 105000.
- R6: An update with equal mapped stages leaves `est_o` unchanged, and so does any cycle with no strobe. Every update stores `state_i`.
- R7: When `gen2_sel_i` is 1, both the new and the stored 3-bit states map to a stage as 0->0, 1->1, 2->1, 3->2, 4->2, 5->3, 6->3, 7->3 before they are compared.
- R8: When `gen2_sel_i` is 0, the stage is `state_i[1:0]` and `state_i[2]` is ignored.
- R9: When `init_i` and `upd_i` are both high in the same cycle, the init action (R3) is taken and the update is dropped.
- R10: Each step of the threshold code moves every computed estimate by exactly 5000. So with default parameters `est_o` stays within 37000..162000 once `valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen2_sel_i | input | 1 | 1 selects the 3-bit state mapping, 0 selects the direct 2-bit stage |
| state_i | input | 3 | Alarm stage or state code |
| thr_i | input | 2 | Threshold code t, unsigned |
| init_i | input | 1 | Init strobe, one cycle |
| upd_i | input | 1 | Update strobe, one cycle |
| est_o | output | 32 | Signed temperature estimate in millidegrees |
| valid_o | output | 1 | Set from the init onward |

## Verification
The hardest case to reach is an update where the raw state codes differ but the mapped stages are equal, or where the stored code was written in one generation mode and is read back in the other. Both come from the stored state alone, so the bench has to walk the state through chosen sequences: 5 then 7, 3 then 4, and 1 then 2 in the 3-bit mode, and codes with bit 2 set in the direct mode. The direction of each estimate change then shows whether the stored value was mapped the right way. A simultaneous init and update is chosen so that the dropped update would have given a different value. A reset in the middle of the run is followed by an update to show that the block has gone back to ignoring updates.

// File: rtl/thermstage_pkg.sv
package thermstage_pkg;
   // Shared constants in millidegrees Celsius
   localparam int STAGE_STEP_MC = 20000;
   localparam int THR_STEP_MC   = 5000;
   localparam int BAND_BASE_MC  = 105000;
   localparam int HYST_MC       = 2000;
   localparam int IDLE_TEMP_MC  = 37000;
   localparam int STG_W         = 2;

   typedef logic [STG_W-1:0] stage_t;

   typedef enum logic [1:0] {
      MOVE_HOLD = 2'd0,
      MOVE_RISE = 2'd1,
      MOVE_FALL = 2'd2
   } move_e;
endpackage

// File: rtl/thermstage_norm.sv
module thermstage_norm #(
   parameter int STATE_W = 3
) (
   input  logic                 gen2_sel_i,
   input  logic [STATE_W-1:0]   code_i,
   output thermstage_pkg::stage_t stage_o
);
   import thermstage_pkg::*;

   localparam int STG_MAX = (1 << STG_W) - 1;

   if (STATE_W < STG_W + 1) begin : g_bad_w
      $error("thermstage_norm: STATE_W must be at least STG_W+1");
   end

   stage_t direct_stage;
   stage_t wide_stage;

   assign direct_stage = code_i[STG_W-1:0];

   // Wide state: half of (code+1), saturated to the top stage
   always_comb begin
      logic [STATE_W:0] half_up;
      half_up = ({1'b0, code_i} + {{STATE_W{1'b0}}, 1'b1}) >> 1;
      if (half_up > (STATE_W+1)'(STG_MAX))
         wide_stage = stage_t'(STG_MAX);
      else
         wide_stage = half_up[STG_W-1:0];
   end

   assign stage_o = gen2_sel_i ? wide_stage : direct_stage;
endmodule

// File: rtl/thermstage_band.sv
module thermstage_band #(
   parameter int THR_W   = 2,
   parameter int EST_W   = 32,
   parameter bit USE_LUT = 1'b0
) (
   input  thermstage_pkg::stage_t stage_i,
   input  logic [THR_W-1:0]       thr_i,
   output logic signed [EST_W-1:0] rise_o,
   output logic signed [EST_W-1:0] fall_o,
   output logic signed [EST_W-1:0] seed_o
);
   import thermstage_pkg::*;

   localparam int THR_N = 1 << THR_W;

   if (EST_W < 20) begin : g_bad_est
      $error("thermstage_band: EST_W too narrow for the estimate range");
   end

   int thr_off;
   int stg_off;

   if (USE_LUT) begin : g_lut
      int thr_tab [THR_N];
      always_comb begin
         for (int i = 0; i < THR_N; i++) thr_tab[i] = i * THR_STEP_MC;
      end
      assign thr_off = thr_tab[thr_i];
   end else begin : g_mul
      assign thr_off = int'(thr_i) * THR_STEP_MC;
   end

   assign stg_off = int'(stage_i) * STAGE_STEP_MC;

   always_comb begin
      int lower_edge;
      lower_edge = stg_off - STAGE_STEP_MC + thr_off + BAND_BASE_MC;
      rise_o = EST_W'(lower_edge + HYST_MC);
      fall_o = EST_W'(stg_off + thr_off + BAND_BASE_MC - HYST_MC);
      if (stage_i == '0)
         seed_o = EST_W'(IDLE_TEMP_MC);
      else
         seed_o = EST_W'(lower_edge);
   end
endmodule

// File: rtl/thermstage_core.sv
module thermstage_core #(
   parameter int STATE_W = 3,
   parameter int EST_W   = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    init_i,
   input  logic                    upd_i,
   input  logic [STATE_W-1:0]      code_i,
   input  thermstage_pkg::stage_t  new_stage_i,
   input  thermstage_pkg::stage_t  old_stage_i,
   input  logic signed [EST_W-1:0] rise_i,
   input  logic signed [EST_W-1:0] fall_i,
   input  logic signed [EST_W-1:0] seed_i,
   output logic [STATE_W-1:0]      prev_code_o,
   output logic signed [EST_W-1:0] est_o,
   output logic                    valid_o
);
   import thermstage_pkg::*;

   logic [STATE_W-1:0]      prev_q;
   logic signed [EST_W-1:0] est_q;
   logic                    ready_q;
   move_e                   move;
   logic                    take_upd;

   assign take_upd = upd_i && !init_i && ready_q;

   always_comb begin
      if (new_stage_i > old_stage_i)      move = MOVE_RISE;
      else if (new_stage_i < old_stage_i) move = MOVE_FALL;
      else                                move = MOVE_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         est_q   <= EST_W'(IDLE_TEMP_MC);
         ready_q <= 1'b0;
      end else if (init_i) begin
         prev_q  <= code_i;
         est_q   <= seed_i;
         ready_q <= 1'b1;
      end else if (take_upd) begin
         prev_q <= code_i;
         unique case (move)
            MOVE_RISE: est_q <= rise_i;
            MOVE_FALL: est_q <= fall_i;
            default:   est_q <= est_q;
         endcase
      end
   end

   assign prev_code_o = prev_q;
   assign est_o       = est_q;
   assign valid_o     = ready_q;
endmodule

// File: rtl/thermstage_est.sv
module thermstage_est #(
   parameter int STATE_W = 3,
   parameter int THR_W   = 2,
   parameter int EST_W   = 32,
   parameter bit USE_LUT = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    gen2_sel_i,
   input  logic [STATE_W-1:0]      state_i,
   input  logic [THR_W-1:0]        thr_i,
   input  logic                    init_i,
   input  logic                    upd_i,
   output logic signed [EST_W-1:0] est_o,
   output logic                    valid_o
);
   import thermstage_pkg::*;

   if (THR_W < 1 || THR_W > 8) begin : g_bad_thr
      $error("thermstage_est: THR_W out of range");
   end

   stage_t                  new_stage;
   stage_t                  old_stage;
   logic [STATE_W-1:0]      prev_code;
   logic signed [EST_W-1:0] rise_v;
   logic signed [EST_W-1:0] fall_v;
   logic signed [EST_W-1:0] seed_v;

   thermstage_norm #(.STATE_W(STATE_W)) u_norm_new (
      .gen2_sel_i(gen2_sel_i), .code_i(state_i),   .stage_o(new_stage));

   thermstage_norm #(.STATE_W(STATE_W)) u_norm_old (
      .gen2_sel_i(gen2_sel_i), .code_i(prev_code), .stage_o(old_stage));

   thermstage_band #(.THR_W(THR_W), .EST_W(EST_W), .USE_LUT(USE_LUT)) u_band (
      .stage_i(new_stage), .thr_i(thr_i),
      .rise_o(rise_v), .fall_o(fall_v), .seed_o(seed_v));

   thermstage_core #(.STATE_W(STATE_W), .EST_W(EST_W)) u_core (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .upd_i(upd_i),
      .code_i(state_i), .new_stage_i(new_stage), .old_stage_i(old_stage),
      .rise_i(rise_v), .fall_i(fall_v), .seed_i(seed_v),
      .prev_code_o(prev_code), .est_o(est_o), .valid_o(valid_o));
endmodule

// File: rtl/thermstage_est_chk.sv
module thermstage_est_chk #(
   parameter int THR_W = 2,
   parameter int EST_W = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    init_i,
   input logic                    upd_i,
   input logic signed [EST_W-1:0] est_o,
   input logic                    valid_o
);
   import thermstage_pkg::*;

   localparam int TOP_MC = 2 * STAGE_STEP_MC + ((1 << THR_W) - 1) * THR_STEP_MC
                           + HYST_MC + BAND_BASE_MC;

   // R1: default output until initialised
   assert_default_before_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> est_o == EST_W'(IDLE_TEMP_MC));

   // R2: update before init is ignored
   assert_upd_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && upd_i && !init_i) |=> (!valid_o && est_o == EST_W'(IDLE_TEMP_MC)));

   // R3: init raises valid on the next cycle
   assert_valid_after_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> valid_o);

   // R3: valid is sticky
   assert_valid_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> valid_o);

   // R6: no strobe, no change
   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && !upd_i) |=> $stable(est_o));

   // R10: estimate stays inside the reachable range
   assert_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (est_o >= EST_W'(IDLE_TEMP_MC) && est_o <= EST_W'(TOP_MC)));
endmodule

bind thermstage_est thermstage_est_chk #(.THR_W(THR_W), .EST_W(EST_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .init_i(init_i), .upd_i(upd_i),
   .est_o(est_o), .valid_o(valid_o));

// File: tb/thermstage_est_test.sv
module thermstage_est_test;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 19;

   typedef struct packed {
      logic        init;
      logic        upd;
      logic        gen2;
      logic [2:0]  st;
      logic [1:0]  thr;
      logic [31:0] exp_est;
      logic        exp_vld;
      logic [7:0]  req;
   } vec_t;

   // Fields: init, upd, gen2, state, thr, expected est, expected valid, requirement
   localparam vec_t VECS [NVEC] = '{
      '{1'b0,1'b1,1'b0,3'd2,2'd0,32'd37000, 1'b0,8'd2},  // R2 ignored before init
      '{1'b1,1'b0,1'b0,3'd0,2'd0,32'd37000, 1'b1,8'd3},  // R3 seed stage 0
      '{1'b0,1'b1,1'b0,3'd1,2'd0,32'd107000,1'b1,8'd4},  // R4 rise 0->1
      '{1'b0,1'b1,1'b0,3'd3,2'd3,32'd162000,1'b1,8'd10}, // R10 R4 rise 1->3 t=3
      '{1'b0,1'b1,1'b0,3'd3,2'd3,32'd162000,1'b1,8'd6},  // R6 equal hold
      '{1'b0,1'b1,1'b0,3'd1,2'd2,32'd133000,1'b1,8'd5},  // R5 fall 3->1 t=2
      '{1'b0,1'b1,1'b0,3'd0,2'd0,32'd103000,1'b1,8'd5},  // R5 fall 1->0
      '{1'b0,1'b1,1'b0,3'd6,2'd1,32'd132000,1'b1,8'd8},  // R8 bit2 ignored, rise 0->2
      '{1'b0,1'b1,1'b0,3'd4,2'd1,32'd108000,1'b1,8'd8},  // R8 bit2 ignored, fall 2->0
      '{1'b1,1'b0,1'b1,3'd5,2'd3,32'd160000,1'b1,8'd3},  // R3 seed wide 5->3
      '{1'b0,1'b1,1'b1,3'd7,2'd3,32'd160000,1'b1,8'd7},  // R7 5,7 both 3
      '{1'b0,1'b1,1'b1,3'd3,2'd0,32'd143000,1'b1,8'd7},  // R7 fall 3->2
      '{1'b0,1'b1,1'b1,3'd4,2'd0,32'd143000,1'b1,8'd6},  // R6 3,4 both 2
      '{1'b0,1'b1,1'b1,3'd1,2'd1,32'd128000,1'b1,8'd7},  // R7 fall 2->1
      '{1'b0,1'b1,1'b1,3'd2,2'd1,32'd128000,1'b1,8'd7},  // R7 1,2 both 1
      '{1'b0,1'b1,1'b1,3'd5,2'd2,32'd157000,1'b1,8'd4},  // R4 rise 1->3 wide
      '{1'b1,1'b1,1'b0,3'd0,2'd0,32'd37000, 1'b1,8'd9},  // R9 init beats update
      '{1'b1,1'b0,1'b0,3'd2,2'd1,32'd130000,1'b1,8'd3},  // R3 re-seed stage 2
      '{1'b0,1'b0,1'b0,3'd3,2'd3,32'd130000,1'b1,8'd6}   // R6 no strobe
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gen2_sel_i = 1'b0;
   logic [2:0]  state_i = '0;
   logic [1:0]  thr_i = '0;
   logic        init_i = 1'b0;
   logic        upd_i = 1'b0;
   logic signed [31:0] est_o;
   logic        valid_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   thermstage_est uut (
      .clk(clk), .rst_n(rst_n), .gen2_sel_i(gen2_sel_i), .state_i(state_i),
      .thr_i(thr_i), .init_i(init_i), .upd_i(upd_i),
      .est_o(est_o), .valid_o(valid_o));

   task automatic check(input string tag, input logic [31:0] exp_e, input logic exp_v);
      n_cmp++;
      if (est_o !== exp_e || valid_o !== exp_v) begin
         n_bad++;
         $display("FAIL %s: est=%0d valid=%0b expected est=%0d valid=%0b",
                  tag, est_o, valid_o, exp_e, exp_v);
      end
   endtask

   task automatic apply(input logic in, input logic up, input logic g2,
                        input logic [2:0] s, input logic [1:0] t);
      @(negedge clk);
      init_i = in; upd_i = up; gen2_sel_i = g2; state_i = s; thr_i = t;
      @(negedge clk);
      init_i = 1'b0; upd_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset state", 32'd37000, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 32'd37000, 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         apply(VECS[i].init, VECS[i].upd, VECS[i].gen2, VECS[i].st, VECS[i].thr);
         check($sformatf("R%0d vector %0d", VECS[i].req, i),
               VECS[i].exp_est, VECS[i].exp_vld);
      end

      // R1 R2: reset mid-run, then an update must not move the estimate
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset mid-run", 32'd37000, 1'b0);
      rst_n = 1'b1;
      apply(1'b0, 1'b1, 1'b0, 3'd3, 2'd3);
      check("R2 update after reset ignored", 32'd37000, 1'b0);

      // R3: seed stage 1 t=0 gives the band floor, valid sticky afterwards
      apply(1'b1, 1'b0, 1'b0, 3'd1, 2'd0);
      check("R3 seed stage 1", 32'd105000, 1'b1);
      repeat (4) @(negedge clk);
      check("R3 valid stays", 32'd105000, 1'b1);

      // R10: rise into stage 2 at each threshold code
      for (int t = 0; t < 4; t++) begin
         apply(1'b1, 1'b0, 1'b0, 3'd1, 2'(t));
         apply(1'b0, 1'b1, 1'b0, 3'd2, 2'(t));
         check($sformatf("R10 rise t=%0d", t), 32'(127000 + t*5000), 1'b1);
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule